// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store, together with the value the base register would take if it is updated. It takes the base register value and one of three offsets: an immediate field, the value of a second register, or that register after a shift or rotate. The offset can be added to the base or subtracted from it. In pre-index mode the access uses the adjusted base, and the base is updated only on request. In post-index mode the access uses the base as it is, and the adjusted base is always written back.

A writeback strobe tells the register file whether to store the new base. When a load would write its data into the same register whose base update is pending, the base update is dropped and a hazard flag is raised instead. All arithmetic wraps modulo 2^32. An optional register stage delays every output by one cycle.

Top module: `ls_agu`

## Requirements
- R1: With `ofs_sel` = 2'b00 the offset is zero, so `new_base` equals `base_val` and a pre-index access address equals `base_val`.
- R2: With `ofs_sel` = 2'b01 the offset is `imm_ofs` zero-extended to 32 bits. It is subtracted from the base when `ofs_sub` = 1 and added when `ofs_sub` = 0.
- R3: With `ofs_sel` = 2'b10 the offset is `idx_val` unchanged, and `sh_type` and `sh_amt` have no effect on it.
- R4: With `ofs_sel` = 2'b11 the offset is `idx_val` shifted by `sh_amt` (0..31). `sh_type` selects the operation: 2'b00 shifts left, 2'b01 shifts right logically, 2'b10 shifts right arithmetically, and 2'b11 rotates right. An amount of 0 passes `idx_val` through unchanged.
- R5: With `post_idx` = 0 (pre-index), `acc_addr` equals base plus or minus the offset.
- R6: With `post_idx` = 1 (post-index), `acc_addr` equals `base_val`, unmodified.
- R7: `new_base` equals base plus or minus the offset, modulo 2^32, in every mode.
- R8: A writeback is requested in post-index mode, and in pre-index mode only when `wb_req` = 1. `wb_en` follows that request unless R9 applies.
- R9: When a writeback is requested, `is_load` = 1 and `base_idx` equals `dst_idx`, `wb_en` is 0 and `wb_hazard` is 1. In every other case `wb_hazard` is 0, and stores are never suppressed.
- R10: With `OUT_REG` = 1 every output appears one clock after its inputs. While `rst` is high the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| base_val | input | 32 | Base register value |
| imm_ofs | input | IMM_W | Immediate offset, unsigned |
| idx_val | input | 32 | Offset register value |
| sh_type | input | 2 | Shift kind applied to `idx_val` |
| sh_amt | input | 5 | Shift or rotate amount |
| ofs_sel | input | 2 | Offset source: none, immediate, register, shifted register |
| ofs_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| post_idx | input | 1 | 1 selects post-index, 0 selects pre-index |
| wb_req | input | 1 | Base update request for pre-index mode |
| is_load | input | 1 | 1 for a load, 0 for a store |
| base_idx | input | 4 | Index of the base register |
| dst_idx | input | 4 | Index of the load destination register |
| acc_addr | output | 32 | Memory access address |
| new_base | output | 32 | Adjusted base value |
| wb_en | output | 1 | Write `new_base` back to the base register |
| wb_hazard | output | 1 | Base update dropped because of a clash with the load destination |

## Verification
The case that is hardest to reach from the ports is the writeback clash. It needs a load, a requested base update from either post-index mode or `wb_req`, and matching 4-bit register indices, all in the same cycle. Random stimulus makes the indices match only about one time in sixteen. The bench therefore steers this case directly in both index modes, and also drives the same index match on a store and on a plain pre-index load. The rotate and arithmetic shifts at amounts 0 and 31 are likewise driven directly with sign-bit patterns, because random values seldom reach those edges.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int XLEN   = 32;
    localparam int SHW    = 5;
    localparam int RIDX_W = 4;

    typedef enum logic [1:0] {
        OFS_NONE  = 2'b00,
        OFS_IMM   = 2'b01,
        OFS_REG   = 2'b10,
        OFS_SHREG = 2'b11
    } ofs_sel_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] nbase;
        logic            wb;
        logic            haz;
    } agu_res_t;

    function automatic logic [XLEN-1:0] barrel(
        input logic [XLEN-1:0] v,
        input sh_kind_e        k,
        input logic [SHW-1:0]  a
    );
        logic [2*XLEN-1:0] dbl;
        logic [XLEN-1:0]   r;
        dbl = {v, v} >> a;
        case (k)
            SH_LSL:  r = v << a;
            SH_LSR:  r = v >> a;
            SH_ASR:  r = XLEN'($signed(v) >>> a);
            default: r = dbl[XLEN-1:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
(
    input  logic [XLEN-1:0] din,
    input  logic [1:0]      kind,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] dout
);
    always_comb begin
        dout = barrel(din, sh_kind_e'(kind), amt);
    end
endmodule

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [1:0]       sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  reg_v,
    input  logic [XLEN-1:0]  shf_v,
    output logic [XLEN-1:0]  ofs
);
    localparam int PAD = XLEN - IMM_W;

    always_comb begin
        case (ofs_sel_e'(sel))
            OFS_NONE:  ofs = '0;
            OFS_IMM:   ofs = {{PAD{1'b0}}, imm};
            OFS_REG:   ofs = reg_v;
            default:   ofs = shf_v;
        endcase
    end
endmodule

// File: rtl/agu_wb_ctrl.sv
module agu_wb_ctrl
    import agu_pkg::*;
(
    input  logic              post,
    input  logic              req,
    input  logic              load,
    input  logic [RIDX_W-1:0] bidx,
    input  logic [RIDX_W-1:0] didx,
    output logic              wb,
    output logic              haz
);
    logic want;
    logic clash;

    always_comb begin
        want  = post | req;
        clash = load && (bidx == didx);
        haz   = want & clash;
        wb    = want & ~clash;
    end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
    import agu_pkg::*;
#(
    parameter int IMM_W   = 12,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   base_val,
    input  logic [IMM_W-1:0]  imm_ofs,
    input  logic [XLEN-1:0]   idx_val,
    input  logic [1:0]        sh_type,
    input  logic [SHW-1:0]    sh_amt,
    input  logic [1:0]        ofs_sel,
    input  logic              ofs_sub,
    input  logic              post_idx,
    input  logic              wb_req,
    input  logic              is_load,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    output logic [XLEN-1:0]   acc_addr,
    output logic [XLEN-1:0]   new_base,
    output logic              wb_en,
    output logic              wb_hazard
);
    logic [XLEN-1:0] shf_c;
    logic [XLEN-1:0] ofs_c;
    logic [XLEN-1:0] sum_c;
    logic            wb_c;
    logic            haz_c;
    agu_res_t        res_c;
    agu_res_t        res_q;

    agu_shifter u_shf (
        .din  (idx_val),
        .kind (sh_type),
        .amt  (sh_amt),
        .dout (shf_c)
    );

    agu_offset_sel #(.IMM_W(IMM_W)) u_sel (
        .sel   (ofs_sel),
        .imm   (imm_ofs),
        .reg_v (idx_val),
        .shf_v (shf_c),
        .ofs   (ofs_c)
    );

    always_comb begin
        sum_c = ofs_sub ? (base_val - ofs_c) : (base_val + ofs_c);
    end

    agu_wb_ctrl u_wb (
        .post (post_idx),
        .req  (wb_req),
        .load (is_load),
        .bidx (base_idx),
        .didx (dst_idx),
        .wb   (wb_c),
        .haz  (haz_c)
    );

    always_comb begin
        res_c.addr  = post_idx ? base_val : sum_c;
        res_c.nbase = sum_c;
        res_c.wb    = wb_c;
        res_c.haz   = haz_c;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_c;
            end

            AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (acc_addr == $past(res_c.addr) && new_base == $past(res_c.nbase))); // R10
        end else begin : g_comb
            always_comb res_q = res_c;
        end
    endgenerate

    assign acc_addr  = res_q.addr;
    assign new_base  = res_q.nbase;
    assign wb_en     = res_q.wb;
    assign wb_hazard = res_q.haz;

    AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (ofs_sel == 2'b00) |-> (sum_c == base_val)); // R1
    AST_SHAMT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ofs_sel == 2'b11 && sh_amt == '0) |-> (ofs_c == idx_val)); // R4
    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (!post_idx && !wb_req) |-> (!wb_c && !haz_c)); // R8
    AST_POST_WB: assert property (@(posedge clk) disable iff (rst)
        (post_idx && !is_load) |-> wb_c); // R8
    AST_HAZ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wb_c && haz_c)); // R9
endmodule

// File: tb/ls_agu_tb.sv
module ls_agu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_val = '0;
    logic [11:0] imm_ofs = '0;
    logic [31:0] idx_val = '0;
    logic [1:0]  sh_type = '0;
    logic [4:0]  sh_amt = '0;
    logic [1:0]  ofs_sel = '0;
    logic        ofs_sub = 1'b0;
    logic        post_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic        is_load = 1'b0;
    logic [3:0]  base_idx = '0;
    logic [3:0]  dst_idx = '0;
    logic [31:0] acc_addr;
    logic [31:0] new_base;
    logic        wb_en;
    logic        wb_hazard;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] n;
        logic        w;
        logic        h;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    ls_agu #(.IMM_W(12), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .base_val(base_val), .imm_ofs(imm_ofs),
        .idx_val(idx_val), .sh_type(sh_type), .sh_amt(sh_amt),
        .ofs_sel(ofs_sel), .ofs_sub(ofs_sub), .post_idx(post_idx),
        .wb_req(wb_req), .is_load(is_load), .base_idx(base_idx),
        .dst_idx(dst_idx), .acc_addr(acc_addr), .new_base(new_base),
        .wb_en(wb_en), .wb_hazard(wb_hazard)
    );

    function automatic logic [31:0] ref_shift(logic [31:0] v, int k, int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) begin
            case (k)
                0: r = r * 2;
                1: r = r / 2;
                2: r = {r[31], r[31:1]};
                default: r = {r[0], r[31:1]};
            endcase
        end
        return r;
    endfunction

    function automatic exp_t model(string tag);
        exp_t e;
        logic [31:0] o;
        logic [31:0] s;
        bit want;
        case (ofs_sel)
            2'd0: o = 0;
            2'd1: o = 32'(imm_ofs);
            2'd2: o = idx_val;
            default: o = ref_shift(idx_val, int'(sh_type), int'(sh_amt));
        endcase
        if (ofs_sub) s = base_val + (~o + 32'd1);
        else         s = base_val + o;
        want  = post_idx || wb_req;
        e.n   = s;
        e.a   = post_idx ? base_val : s;
        e.h   = want && is_load && (base_idx == dst_idx);
        e.w   = want && !e.h;
        e.tag = tag;
        return e;
    endfunction

    task automatic check_out();
        exp_t e;
        e = q.pop_front();
        total++;
        if (acc_addr !== e.a || new_base !== e.n || wb_en !== e.w || wb_hazard !== e.h) begin
            bad++;
            $display("FAIL %s: got addr=%h nb=%h wb=%b hz=%b exp addr=%h nb=%h wb=%b hz=%b",
                     e.tag, acc_addr, new_base, wb_en, wb_hazard, e.a, e.n, e.w, e.h);
        end
    endtask

    task automatic apply(input logic [31:0] b, input logic [11:0] im, input logic [31:0] x,
                         input logic [1:0] st, input logic [4:0] sa, input logic [1:0] sel,
                         input logic sb, input logic po, input logic wr, input logic ld,
                         input logic [3:0] bi, input logic [3:0] di, input string tag);
        base_val = b; imm_ofs = im; idx_val = x; sh_type = st; sh_amt = sa;
        ofs_sel = sel; ofs_sub = sb; post_idx = po; wb_req = wr; is_load = ld;
        base_idx = bi; dst_idx = di;
        q.push_back(model(tag));
        @(negedge clk);
        check_out();
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        base_val = 32'hDEAD_BEEF; idx_val = 32'h1234_5678; ofs_sel = 2'd3; post_idx = 1'b1;
        repeat (3) @(negedge clk);
        total++;
        if (acc_addr !== 0 || new_base !== 0 || wb_en !== 0 || wb_hazard !== 0) begin
            bad++;
            $display("FAIL R10 reset: got addr=%h nb=%h wb=%b hz=%b exp all zero",
                     acc_addr, new_base, wb_en, wb_hazard);
        end
        rst = 1'b0;
        // R1 plain base address
        apply(32'h0000_0200, 12'hFFF, 32'h55, 2'd0, 5'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd0, "R1");
        apply(32'h8000_0000, 12'h000, 32'h0,  2'd0, 5'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2, "R1");
        // R2 immediate add, subtract, wraparound
        apply(32'd200, 12'd12, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R2");
        apply(32'd200, 12'd12, 32'h0, 2'd0, 5'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R2");
        apply(32'd4,   12'd8,  32'h0, 2'd0, 5'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R2");
        apply(32'hFFFF_FFF0, 12'hFFF, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 4'd2, "R2");
        // R3 register offset ignores shift fields
        apply(32'h1000, 12'h7, 32'h20, 2'd3, 5'd9, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R3");
        apply(32'h1000, 12'h7, 32'h20, 2'd1, 5'd31, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R3");
        // R4 shifted register offsets
        apply(32'h100, 12'h0, 32'h3, 2'd0, 5'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h100, 12'h0, 32'h3, 2'd0, 5'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h0, 12'h0, 32'h8000_0010, 2'd1, 5'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h0, 12'h0, 32'h8000_0010, 2'd2, 5'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h0, 12'h0, 32'h8000_0000, 2'd2, 5'd31, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h0, 12'h0, 32'h0000_0013, 2'd3, 5'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        apply(32'h0, 12'h0, 32'h0000_0001, 2'd3, 5'd31, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        for (int k = 0; k < 4; k++)
            apply(32'h40, 12'h0, 32'hC000_0005, 2'(k), 5'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, "R4");
        // R5 R6 pre and post index addresses
        apply(32'd200, 12'd12, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 4'd2, "R5");
        apply(32'd300, 12'd4,  32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 4'd2, "R6");
        apply(32'd300, 12'd0,  32'h2, 2'd0, 5'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 4'd2, "R6");
        // R8 writeback request rules
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd4, "R8");
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd4, "R8");
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd4, "R8");
        // R9 clash suppression
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5, 4'd5, "R9");
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5, 4'd5, "R9");
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 4'd5, "R9");
        apply(32'h10, 12'h4, 32'h0, 2'd0, 5'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 4'd5, "R9");
        // R7 random mix
        for (int i = 0; i < 400; i++)
            apply($urandom, 12'($urandom), $urandom, 2'($urandom), 5'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), "R7");
        // R10 reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        total++;
        if (acc_addr !== 0 || new_base !== 0 || wb_en !== 0 || wb_hazard !== 0) begin
            bad++;
            $display("FAIL R10 reset: got addr=%h nb=%h wb=%b hz=%b exp all zero",
                     acc_addr, new_base, wb_en, wb_hazard);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule